// File: doc/BRIEF.md
# Synchronous USB Bridge Write Port

This block moves 16-bit words from an internal valid/ready stream onto the write side of an external USB controller. That controller exposes a synchronous slave FIFO: a 16-bit data bus, an active-low write strobe and a busy flag it raises when it cannot take more data. A word crosses the internal boundary only in a cycle where valid and ready are both high. Each accepted word then appears on the external bus for exactly one strobe cycle, in acceptance order.

The busy flag is registered once before any decision uses it. The stream ready is also a flop. Together these two registers let the internal side push a word in the cycle after busy rises. A small skid buffer, two entries by default, holds such late words until the controller frees up again. The external data and strobe come straight from flops, so the pins never glitch. Everything runs on one clock with an active-low asynchronous reset.

Top module: `usb_wr_bridge`

## Requirements
- R1: While reset is asserted, the write strobe is high (inactive), stream ready is low and the external data bus is zero.
- R2: A stream word is taken only at a clock edge where both valid and ready are high, and each such edge takes exactly one word.
- R3: The write strobe is low in exactly those cycles that present a word on the external data bus. Each low cycle carries one buffered word.
- R4: The write strobe is driven low after a clock edge only if the busy input was low two clock edges before that edge.
- R5: If the busy input was high at some edge, stream ready is low throughout the cycle that begins two edges later.
- R6: Words leave on the external bus in the order they were accepted, with no loss and no duplication, under any pattern of valid and busy.
- R7: A word accepted after busy has risen but before ready has dropped is kept in the skid buffer. The buffer never holds more than its depth, and ready is never high while the buffer is full.
- R8: While the write strobe is high, the external data bus keeps its previous value.
- R9: Once busy has been low for two edges, a buffered word goes out at the next edge. With valid held high and busy held low, a new word is written on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Single clock for all logic |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | 16 | Stream word in |
| s_valid_i | input | 1 | Stream word valid |
| s_ready_o | output | 1 | Block can take a word this cycle |
| usb_data_o | output | 16 | Data bus to the controller |
| usb_wr_no | output | 1 | Write strobe to the controller, active low |
| usb_busy_i | input | 1 | Controller busy flag, high means no write allowed |

## Verification
Two things can happen at the same clock edge: the stream pushes a word into the skid buffer, and the output stage pops a word onto the external bus. The worst case is a push in the cycle right after busy rises, when the pop has already stopped, so the buffer grows by one. This is provoked by holding valid high through a busy rise, and then by random busy toggling at several densities. A cycle-accurate queue model judges ready, the strobe and the data on every cycle, and a separate scoreboard confirms order and completeness.

// File: rtl/usb_wr_pkg.sv
package usb_wr_pkg;
  // bits needed to count 0..depth
  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/usb_wr_skid.sv
module usb_wr_skid #(
  parameter int DW    = 16,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = usb_wr_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/usb_wr_flow.sv
module usb_wr_flow #(
  parameter int DEPTH = 2,
  localparam int CW   = usb_wr_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [CW-1:0] cnt_i,
  output logic          busy_q_o,
  output logic          ready_o
);
  logic          busy_q, ready_q, ready_d;
  logic [CW:0]   cnt_d;

  // occupancy after this edge; ready must leave room for one more push
  assign cnt_d   = {1'b0, cnt_i} + (CW+1)'(push_i) - (CW+1)'(pop_i);
  assign ready_d = !busy_q && (cnt_d < (CW+1)'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b1;
      ready_q <= 1'b0;
    end else begin
      busy_q  <= busy_i;
      ready_q <= ready_d;
    end
  end

  assign busy_q_o = busy_q;
  assign ready_o  = ready_q;
endmodule

// File: rtl/usb_wr_out.sv
module usb_wr_out #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          wr_no
);
  logic [DW-1:0] data_q;
  logic          wr_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      wr_nq  <= 1'b1;
    end else begin
      wr_nq <= !pop_i;
      if (pop_i) data_q <= data_i;
    end
  end

  assign data_o = data_q;
  assign wr_no  = wr_nq;
endmodule

// File: rtl/usb_wr_bridge.sv
module usb_wr_bridge #(
  parameter int DW    = 16,
  parameter int DEPTH = 2,
  localparam int CW   = usb_wr_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_valid_i,
  output logic          s_ready_o,
  output logic [DW-1:0] usb_data_o,
  output logic          usb_wr_no,
  input  logic          usb_busy_i
);
  logic          busy_q, push, pop;
  logic [DW-1:0] head_data;
  logic [CW-1:0] fifo_cnt;

  assign push = s_valid_i && s_ready_o;
  assign pop  = !busy_q && (fifo_cnt != '0);

  usb_wr_flow #(.DEPTH(DEPTH)) u_flow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (usb_busy_i),
    .push_i   (push),
    .pop_i    (pop),
    .cnt_i    (fifo_cnt),
    .busy_q_o (busy_q),
    .ready_o  (s_ready_o)
  );

  usb_wr_skid #(.DW(DW), .DEPTH(DEPTH)) u_skid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (s_data_i),
    .pop_i   (pop),
    .rdata_o (head_data),
    .cnt_o   (fifo_cnt)
  );

  usb_wr_out #(.DW(DW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pop_i  (pop),
    .data_i (head_data),
    .data_o (usb_data_o),
    .wr_no  (usb_wr_no)
  );
endmodule

// File: rtl/usb_wr_bridge_chk.sv
module usb_wr_bridge_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 2,
  localparam int CW   = usb_wr_pkg::cnt_bits(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          s_valid_i,
  input logic          s_ready_o,
  input logic [DW-1:0] usb_data_o,
  input logic          usb_wr_no,
  input logic          usb_busy_i,
  input logic [CW-1:0] fifo_cnt
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) reset_idle_chk: assert (usb_wr_no && !s_ready_o && usb_data_o == '0);
  end

  // R3
  strobe_has_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !usb_wr_no |-> $past(fifo_cnt) != '0);

  // R4
  strobe_needs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !usb_wr_no |-> !$past(usb_busy_i, 2));

  // R5
  busy_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(usb_busy_i, 2) |-> !s_ready_o);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> fifo_cnt < CW'(DEPTH));

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_wr_no |-> $stable(usb_data_o));

  // R2
  valid_low_no_growth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_valid_i |=> fifo_cnt <= $past(fifo_cnt));
endmodule

bind usb_wr_bridge usb_wr_bridge_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_valid_i  (s_valid_i),
  .s_ready_o  (s_ready_o),
  .usb_data_o (usb_data_o),
  .usb_wr_no  (usb_wr_no),
  .usb_busy_i (usb_busy_i),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/usb_wr_bridge_bench.sv
module usb_wr_bridge_bench;
  localparam int DW    = 16;
  localparam int DEPTH = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] d_data = '0;
  logic          d_valid = 1'b0;
  logic          d_busy = 1'b0;
  logic          s_ready;
  logic [DW-1:0] usb_data;
  logic          usb_wr_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int pv = 0, pb = 0;
  bit done = 1'b0;

  // reference model state
  logic [DW-1:0] q_m[$];
  logic          busy_m = 1'b1, ready_m = 1'b0, wr_m = 1'b1;
  logic [DW-1:0] data_m = '0;
  int            max_occ = 0;
  // scoreboard
  logic [DW-1:0] sb[$];
  int n_in = 0, n_out = 0;

  always #4 clk = ~clk;

  usb_wr_bridge #(.DW(DW), .DEPTH(DEPTH)) u_usb_wr_bridge (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .s_data_i   (d_data),
    .s_valid_i  (d_valid),
    .s_ready_o  (s_ready),
    .usb_data_o (usb_data),
    .usb_wr_no  (usb_wr_n),
    .usb_busy_i (d_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // behavioural model, advanced on every edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q_m.delete();
      busy_m = 1'b1; ready_m = 1'b0; wr_m = 1'b1; data_m = '0;
    end else begin
      bit pop_m, acc_m;
      pop_m = !busy_m && q_m.size() > 0;
      acc_m = d_valid && ready_m;
      if (pop_m) begin
        data_m = q_m.pop_front();
        wr_m = 1'b0;
      end else wr_m = 1'b1;
      if (acc_m) q_m.push_back(d_data);
      if (q_m.size() > max_occ) max_occ = q_m.size();
      ready_m = !busy_m && q_m.size() < DEPTH;
      busy_m = d_busy;
    end
    if (cyc > 200000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 200000);
      finish_run();
    end
  end

  // compare, then drive next stimulus
  always @(negedge clk) begin
    if (!rst_n) begin
      // R1
      chk(usb_wr_n === 1'b1 && s_ready === 1'b0 && usb_data === '0, "R1 reset state",
          {usb_wr_n, s_ready}, 2'b10);
      d_valid <= 1'b0;
      d_busy  <= 1'b0;
    end else begin
      // R5 ready matches model timing
      chk(s_ready === ready_m, "R5 ready", s_ready, ready_m);
      // R3 R4 R9 strobe timing
      chk(usb_wr_n === wr_m, "R4 strobe", usb_wr_n, wr_m);
      // R8 R3 data bus
      chk(usb_data === data_m, "R8 data bus", usb_data, data_m);
      if (usb_wr_n === 1'b0) begin
        if (sb.size() == 0) chk(1'b0, "R6 extra word", usb_data, 0);
        else begin
          logic [DW-1:0] e;
          e = sb.pop_front();
          // R2 R6 order and content
          chk(usb_data === e, "R6 order", usb_data, e);
        end
        n_out++;
      end
      d_valid = ($urandom_range(99) < pv);
      d_busy  = ($urandom_range(99) < pb);
      d_data  = DW'($urandom);
      if (d_valid && s_ready) begin
        sb.push_back(d_data);
        n_in++;
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // steady flow: one word per cycle
    pv = 100; pb = 0;
    repeat (20) @(posedge clk);
    // busy rises while streaming: late word lands in skid
    pb = 100;
    repeat (12) @(posedge clk);
    pb = 0;
    repeat (20) @(posedge clk);
    pv = 50; pb = 50;  repeat (1000) @(posedge clk);
    pv = 90; pb = 20;  repeat (1000) @(posedge clk);
    pv = 30; pb = 80;  repeat (1000) @(posedge clk);
    pv = 100; pb = 10; repeat (1000) @(posedge clk);
    // drain
    pv = 0; pb = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    // R6 nothing lost
    chk(sb.size() == 0 && n_in == n_out, "R6 all words written", n_out, n_in);
    // R7 skid reached full depth
    chk(max_occ == DEPTH, "R7 skid occupancy", max_occ, DEPTH);
    // R2 words accepted at all
    chk(n_in > 1000, "R2 traffic accepted", n_in, 1000);
    finish_run();
  end
endmodule